// File: doc/BRIEF.md
# Ten-Bit Raw Line Packer

This block takes one image line at a time as a stream of 10-bit samples and packs them into 256-bit words for a memory writer. Each word holds 25 samples in 250 bits. The 6 bits at the top of the word are always zero. Colour order has no effect on packing, because every supported sample format is 10 bits wide. At the end of a line the block zero-fills the unused sample slots of the last word. If the line has produced an odd number of words, it adds one all-zero word, so that every line takes a whole number of 64-byte units. One 64-byte unit holds 50 samples.

Both stream edges use valid/ready. The input is transferred on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high only when the output holds no word, so a stalled consumer pauses the source without losing or repeating a sample. While `out_valid` is high and `out_ready` is low, the output word and its last flag stay frozen. Line width is limited to `MAX_WIDTH` samples. Samples past that limit are accepted and dropped. After the final word of a line is taken, `line_bytes` reports the size of the line in bytes.

Top module: `rawpack_line_packer`

## Requirements
- R1: Sample k of a group (k = 0..24, counted from the start of the group) is placed at bits [10k+9:10k] of the output word. Sample 0 is in the least significant position, and each word carries 25 consecutive samples of the line.
- R2: Bits [255:250] of every output word are zero.
- R3: If a line ends part-way through a group, the group is still emitted, and its unused sample slots are zero.
- R4: Every complete line produces an even number of words, 2*ceil(n/50) for n kept samples. When the data words number an odd count, one extra all-zero word follows. `out_last` is high on the final word of the line only.
- R5: One cycle after the last word of a line is taken, `line_bytes` equals ceil(n/50)*64 for n kept samples. It holds that value until the next line's last word is taken.
- R6: A line keeps at most `MAX_WIDTH` (4224) samples. Later samples up to the end-of-line marker are accepted and discarded, so a longer line reports 5440 bytes.
- R7: An accepted sample with `in_sol` high starts a new line. Any partly filled group from an unfinished line is discarded. Words of that line already fully packed are still delivered, and none carries `out_last`.
- R8: A sample accepted outside a line (no `in_sol` since the previous end-of-line) produces no output.
- R9: `in_ready` equals the inverse of `out_valid`. While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` stay unchanged and no sample is lost or repeated.
- R10: After reset, `out_valid` is 0, `in_ready` is 1 and `line_bytes` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Sample can be taken |
| in_pix | input | 10 | Sample value |
| in_sol | input | 1 | Sample is the first of a line |
| in_eol | input | 1 | Sample is the last of a line |
| out_valid | output | 1 | Packed word offered |
| out_ready | input | 1 | Consumer takes the word |
| out_data | output | 256 | Packed word |
| out_last | output | 1 | Final word of the line |
| line_bytes | output | 13 | Byte size of the last finished line |

## Verification
The properties assume that a new line is marked by an accepted `in_sol`. They also assume the sample limit is not a multiple of 25, so that a line always ends with data still in the group. The word-parity and byte-count checks rest on both of these. Under these assumptions, a line that is cut short does not disturb the count for the next line. The stimulus always starts a line with `in_sol`, keeps the default limit, and adds only marked aborts and stray samples. It drives `out_ready` randomly, or holds it low for long stretches, so the hold and back-pressure properties are exercised heavily.

// File: rtl/rawpack_pkg.sv
package rawpack_pkg;
  function automatic int cdiv(input int a, input int b);
    return (a + b - 1) / b;
  endfunction
endpackage

// File: rtl/rawpack_group_acc.sv
module rawpack_group_acc #(
  parameter int PIX_W  = 10,
  parameter int SLOTS  = 25,
  parameter int WORD_W = 256,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int PAY_W  = SLOTS * PIX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              restart,
  input  logic              wr,
  input  logic              flush,
  input  logic [PIX_W-1:0]  pix,
  output logic              full_next,
  output logic              has_data,
  output logic [WORD_W-1:0] word_next
);
  logic [PAY_W-1:0]  data_q;
  logic [PAY_W-1:0]  base;
  logic [SLOT_W-1:0] slot_q;
  logic [SLOT_W-1:0] slot_eff;

  assign base      = restart ? '0 : data_q;
  assign slot_eff  = restart ? '0 : slot_q;
  assign full_next = wr && (slot_eff == SLOT_W'(SLOTS - 1));
  assign has_data  = wr || (slot_eff != '0);

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    assign word_next[k*PIX_W +: PIX_W] =
      (wr && slot_eff == SLOT_W'(k)) ? pix : base[k*PIX_W +: PIX_W];
  end
  assign word_next[WORD_W-1:PAY_W] = '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      slot_q <= '0;
    end else if (step) begin
      if (flush || (restart && !wr)) begin
        data_q <= '0;
        slot_q <= '0;
      end else if (wr) begin
        data_q <= word_next[PAY_W-1:0];
        slot_q <= slot_eff + SLOT_W'(1);
      end
    end
  end
endmodule

// File: rtl/rawpack_line_track.sv
module rawpack_line_track #(
  parameter int MAX_WIDTH = 4224,
  parameter int PCNT_W    = 13,
  parameter int WCNT_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              sol,
  input  logic              eol,
  input  logic              word_inc,
  output logic              active,
  output logic              keep,
  output logic              wc_odd,
  output logic [WCNT_W-1:0] word_cnt
);
  logic              in_line_q;
  logic [PCNT_W-1:0] pix_cnt_q;
  logic [PCNT_W-1:0] pc_eff;

  assign active = take && (sol || in_line_q);
  assign pc_eff = sol ? '0 : pix_cnt_q;
  assign keep   = active && (pc_eff < PCNT_W'(MAX_WIDTH));
  assign wc_odd = !sol && word_cnt[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_line_q <= 1'b0;
      pix_cnt_q <= '0;
      word_cnt  <= '0;
    end else begin
      if (active) begin
        in_line_q <= !eol;
        pix_cnt_q <= keep ? pc_eff + PCNT_W'(1) : pc_eff;
      end
      if (active && sol) word_cnt <= word_inc ? WCNT_W'(1) : '0;
      else if (word_inc) word_cnt <= word_cnt + WCNT_W'(1);
    end
  end
endmodule

// File: rtl/rawpack_line_packer.sv
module rawpack_line_packer
  import rawpack_pkg::*;
#(
  parameter int PIX_W     = 10,
  parameter int SLOTS     = 25,
  parameter int WORD_W    = 256,
  parameter int MAX_WIDTH = 4224,
  localparam int PCNT_W   = $clog2(MAX_WIDTH + 1),
  localparam int MAX_WRDS = 2 * cdiv(MAX_WIDTH, 2 * SLOTS),
  localparam int WCNT_W   = $clog2(MAX_WRDS + 1),
  localparam int BYTE_SH  = $clog2(WORD_W / 8),
  localparam int BYTES_W  = WCNT_W + BYTE_SH
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [PIX_W-1:0]   in_pix,
  input  logic               in_sol,
  input  logic               in_eol,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [WORD_W-1:0]  out_data,
  output logic               out_last,
  output logic [BYTES_W-1:0] line_bytes
);
  logic take, active, keep, wc_odd, close, emit, load, word_inc;
  logic full_next, has_data, pad_pend, out_hs, after_odd;
  logic [WORD_W-1:0] word_next;
  logic [WCNT_W-1:0] word_cnt;

  assign in_ready  = !out_valid && !pad_pend;
  assign take      = in_valid && in_ready;
  assign out_hs    = out_valid && out_ready;
  assign close     = active && in_eol;
  assign emit      = full_next || (close && has_data);
  assign after_odd = wc_odd ^ emit;
  assign load      = emit || (close && wc_odd);
  assign word_inc  = (take && load) || (out_hs && pad_pend);

  rawpack_line_track #(
    .MAX_WIDTH(MAX_WIDTH), .PCNT_W(PCNT_W), .WCNT_W(WCNT_W)
  ) track_i (
    .clk(clk), .rst_n(rst_n), .take(take), .sol(in_sol), .eol(in_eol),
    .word_inc(word_inc), .active(active), .keep(keep), .wc_odd(wc_odd),
    .word_cnt(word_cnt)
  );

  rawpack_group_acc #(
    .PIX_W(PIX_W), .SLOTS(SLOTS), .WORD_W(WORD_W)
  ) acc_i (
    .clk(clk), .rst_n(rst_n), .step(active), .restart(in_sol), .wr(keep),
    .flush(emit), .pix(in_pix), .full_next(full_next), .has_data(has_data),
    .word_next(word_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_data   <= '0;
      out_last   <= 1'b0;
      pad_pend   <= 1'b0;
      line_bytes <= '0;
    end else if (out_hs) begin
      if (out_last) line_bytes <= {word_cnt, {BYTE_SH{1'b0}}};
      if (pad_pend) begin
        out_data <= '0;
        out_last <= 1'b1;
        pad_pend <= 1'b0;
      end else begin
        out_valid <= 1'b0;
        out_last  <= 1'b0;
      end
    end else if (take && load) begin
      out_valid <= 1'b1;
      out_data  <= emit ? word_next : '0;
      out_last  <= close && !(emit && after_odd);
      pad_pend  <= close && emit && after_odd;
    end
  end
endmodule

// File: rtl/rawpack_line_packer_chk.sv
module rawpack_line_packer_chk #(
  parameter int PIX_W   = 10,
  parameter int SLOTS   = 25,
  parameter int WORD_W  = 256,
  parameter int BYTES_W = 13
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic               in_sol,
  input logic               out_valid,
  input logic               out_ready,
  input logic [WORD_W-1:0]  out_data,
  input logic               out_last,
  input logic [BYTES_W-1:0] line_bytes
);
  logic        hs;
  logic [15:0] cnt_q;
  logic [15:0] total_q;

  assign hs = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      total_q <= '0;
    end else if (in_valid && in_ready && in_sol) begin
      cnt_q <= '0;
    end else if (hs) begin
      if (out_last) begin
        cnt_q   <= '0;
        total_q <= cnt_q + 16'd1;
      end else begin
        cnt_q <= cnt_q + 16'd1;
      end
    end
  end

  a_r2_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_data[WORD_W-1:SLOTS*PIX_W] == '0);

  a_r4_even_words: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && out_last) |-> cnt_q[0]);

  a_r5_byte_count: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && out_last) |=> line_bytes == BYTES_W'({total_q, 5'b0}));

  a_r9_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_data) && $stable(out_last));

  a_r9_ready_low: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);
endmodule

bind rawpack_line_packer rawpack_line_packer_chk #(
  .PIX_W(PIX_W), .SLOTS(SLOTS), .WORD_W(WORD_W), .BYTES_W(BYTES_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_sol(in_sol), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_last(out_last), .line_bytes(line_bytes)
);

// File: tb/rawpack_line_packer_tb_top.sv
module rawpack_line_packer_tb_top;
  localparam int MAXW = 4224;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0, in_sol = 1'b0, in_eol = 1'b0;
  logic [9:0]   in_pix = '0;
  logic         in_ready, out_valid, out_last;
  logic         out_ready = 1'b0;
  logic [255:0] out_data;
  logic [12:0]  line_bytes;

  int checks = 0, fails = 0;
  int ready_mode = 0;
  logic [255:0] exp_d[$];
  bit           exp_l[$];

  bit           m_in_line = 0;
  int           m_cnt = 0, m_slot = 0, m_words = 0;
  logic [255:0] m_acc = '0;

  bit           prev_stall = 0;
  logic [255:0] prev_d;
  logic         prev_l;

  rawpack_line_packer dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pix(in_pix), .in_sol(in_sol), .in_eol(in_eol), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
    .line_bytes(line_bytes)
  );

  task automatic check(input bit cond, input string msg);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s", msg);
    end
  endtask

  function automatic int exp_bytes(input int n);
    int k;
    k = (n > MAXW) ? MAXW : n;
    return ((k + 49) / 50) * 64;
  endfunction

  task automatic model_pix(input logic [9:0] p, input bit sol, input bit eol);
    if (sol) begin
      m_in_line = 1; m_cnt = 0; m_slot = 0; m_words = 0; m_acc = '0;
    end
    if (!m_in_line) return;
    if (m_cnt < MAXW) begin
      m_acc[m_slot*10 +: 10] = p;
      m_slot++;
      m_cnt++;
    end
    if (m_slot == 25 || (eol && m_slot > 0)) begin
      exp_d.push_back(m_acc); exp_l.push_back(1'b0);
      m_words++; m_acc = '0; m_slot = 0;
    end
    if (eol) begin
      if (m_words % 2 == 1) begin
        exp_d.push_back('0); exp_l.push_back(1'b0);
        m_words++;
      end
      if (exp_l.size() > 0) exp_l[exp_l.size()-1] = 1'b1;
      m_in_line = 0;
    end
  endtask

  task automatic send(input logic [9:0] p, input bit sol, input bit eol);
    in_valid = 1'b1; in_pix = p; in_sol = sol; in_eol = eol;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_sol = 1'b0; in_eol = 1'b0;
  endtask

  task automatic wait_drain();
    while (exp_d.size() != 0 || out_valid) @(negedge clk);
  endtask

  // pat=1: sample i carries value i+1; otherwise random values
  task automatic send_line(input int n, input bit pat, input bit with_eol, input string tag);
    logic [9:0] p;
    for (int i = 0; i < n; i++) begin
      p = pat ? 10'(i + 1) : 10'($urandom % 1024);
      model_pix(p, i == 0, with_eol && i == n - 1);
      send(p, i == 0, with_eol && i == n - 1);
    end
    if (with_eol) begin
      wait_drain();
      check(line_bytes == 13'(exp_bytes(n)),
            $sformatf("%s line_bytes width=%0d actual=%0d expected=%0d",
                      tag, n, line_bytes, exp_bytes(n)));
    end
  endtask

  // output monitor and ready driver, away from the rising edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall)
        check(out_valid && out_data == prev_d && out_last == prev_l,
              $sformatf("R9 hold actual=%h/%0b expected=%h/%0b", out_data, out_last, prev_d, prev_l));
      check(in_ready == !out_valid,
            $sformatf("R9 in_ready actual=%0b expected=%0b", in_ready, !out_valid));
      case (ready_mode)
        1: out_ready = 1'b1;
        2: out_ready = 1'b0;
        default: out_ready = ($urandom % 4) != 0;
      endcase
      if (out_valid && out_ready) begin
        check(out_data[255:250] == 6'd0,
              $sformatf("R2 spare bits actual=%h expected=0", out_data[255:250]));
        if (exp_d.size() == 0) begin
          check(1'b0, $sformatf("R8 unexpected word actual=%h expected=none", out_data));
        end else begin
          check(out_data == exp_d[0],
                $sformatf("R1/R3 data actual=%h expected=%h", out_data, exp_d[0]));
          check(out_last == exp_l[0],
                $sformatf("R4 last flag actual=%0b expected=%0b", out_last, exp_l[0]));
          void'(exp_d.pop_front());
          void'(exp_l.pop_front());
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_d     = out_data;
      prev_l     = out_last;
    end
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20250611));
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0 && in_ready == 1'b1 && line_bytes == 13'd0,
          $sformatf("R10 reset actual=%0b%0b/%0d expected=01/0", out_valid, in_ready, line_bytes));
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && in_ready == 1'b1 && line_bytes == 13'd0,
          $sformatf("R10 after reset actual=%0b%0b/%0d expected=01/0", out_valid, in_ready, line_bytes));

    ready_mode = 1;
    send_line(25, 1, 1, "R1 R4 R5 exact group");
    send_line(1, 1, 1, "R3 R4 R5 single sample");
    send_line(50, 1, 1, "R4 R5 one unit");
    send_line(51, 0, 1, "R3 R4 R5 unit plus one");
    ready_mode = 0;
    send_line(26, 0, 1, "R3 R5 random ready");

    // R7: unfinished line of 30, then a fresh line of 10
    send_line(30, 0, 0, "R7 aborted");
    send_line(10, 0, 1, "R7 restart");

    // R8: stray samples outside a line
    send(10'h155, 1'b0, 1'b0);
    send(10'h2aa, 1'b0, 1'b1);
    repeat (5) @(negedge clk);
    check(out_valid == 1'b0, $sformatf("R8 stray output actual=%0b expected=0", out_valid));
    check(line_bytes == 13'(exp_bytes(10)),
          $sformatf("R8 line_bytes actual=%0d expected=%0d", line_bytes, exp_bytes(10)));

    // R9: consumer stalled for a long stretch mid-line
    ready_mode = 2;
    fork
      send_line(60, 0, 1, "R9 stalled line");
      begin
        repeat (80) @(negedge clk);
        check(out_valid && !in_ready,
              $sformatf("R9 stall actual=%0b%0b expected=10", out_valid, in_ready));
        ready_mode = 0;
      end
    join

    // R6: over-wide line is clamped
    send_line(4300, 0, 1, "R6 clamp");
    send_line(MAXW, 0, 1, "R6 at limit");

    for (int j = 0; j < 12; j++) begin
      ready_mode = (j % 3 == 0) ? 1 : 0;
      send_line(1 + int'($urandom % 400), 0, 1, "R5 random line");
    end

    repeat (5) @(negedge clk);
    check(exp_d.size() == 0, $sformatf("R4 leftover words actual=%0d expected=0", exp_d.size()));
    finish_run();
  end
endmodule